// File: doc/BRIEF.md
# Four-Channel Buffered Pulse-Width Modulator

This block produces four independent pulse-width modulated outputs, each driven by a 16-bit tick counter whose tick rate is set by a power-of-two divider of the system clock. Software programs each channel through a small synchronous register port. It sets a divider exponent and an output polarity, a duty value that counts the inactive ticks at the start of each period, and a period length in ticks. Channels are started and stopped through write-one bitmask registers.

While a channel runs, new duty and period values are held in staging registers and move into the live registers only when the current period ends, so a waveform never carries a half-updated period. Each period end that applies a staged value raises a per-channel flag. The flags are read as one word, and the read clears them. A stop request lets the current period finish, and the channel's status bit stays high until the stop takes effect.

Top module: `pwm_ctrl`

## Requirements
- R1: Register map. Global registers: start mask at 0x004, stop mask at 0x008, running status at 0x00C, update flags at 0x01C. Channel c occupies 0x200 + 0x20*c, with mode at +0x00, live duty at +0x04, staged duty at +0x08, live period at +0x0C and staged period at +0x10. A read of any other offset returns zero. Read data appears on the port in the cycle after the read strobe.
- R2: Mode register. Bits [3:0] hold the exponent N, and the channel counter advances once every 2^N clock cycles. Values of N above 10 act as 10. Bit 9 selects the polarity: 0 means the active level is high, 1 means the active level is low.
- R3: A period lasts P ticks, with the counter running 0..P-1. The output is at its active level while the counter is greater than or equal to the duty D, which gives P-D active ticks per period. When D >= P the output is inactive for the whole period. When D = 0 it is active for the whole period.
- R4: Writing a 1 to bit c of the start register starts a stopped channel with its counter and divider at zero, and sets status bit c. Zero bits have no effect.
- R5: Writing a 1 to bit c of the stop register lets the channel finish its current period. Status bit c stays 1 until that period ends, then reads 0. A stopped channel drives its inactive level.
- R6: While a channel runs, writes to its duty or period registers (live or staged offsets) are held. They are copied to the live values at the next period end. Live offsets read back the values in use, and staged offsets read back the held value.
- R7: While a channel is stopped, a write to its duty or period (either offset) loads the live value at once.
- R8: Flag bit c is set at the period end of channel c that applies a staged value. A read of 0x01C returns the flags and clears them all. A flag set in the same cycle as that read is kept for the next read.
- R9: After reset, all registers are zero, all outputs are low and no channel runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pwm_out | output | 4 | Waveform output, one bit per channel |

## Verification
Two functions can land in the same clock edge: a channel's period end that applies a staged value and sets its flag, and a software read of the flag register that clears every flag. The bench provokes this by starting a channel with the divider at one and staging a new duty. It then raises the read strobe in exactly the cycle where the counter holds P-1. The first read must show the bit clear, and a second read must show it set. This proves that setting a flag takes precedence over the read-clear. A related collision comes from a stop request during a period that also applies a staged change: the waveform must switch to the new duty only at the boundary and must go to its inactive level at the next boundary after the stop.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int unsigned PWM_CH      = 4;
    localparam int unsigned PWM_CNT_W   = 16;
    localparam int unsigned PWM_DATA_W  = 32;
    localparam int unsigned PWM_ADDR_W  = 12;
    localparam int unsigned PWM_PRE_MAX = 10;

    localparam logic [11:0] OFS_START   = 12'h004;
    localparam logic [11:0] OFS_STOP    = 12'h008;
    localparam logic [11:0] OFS_STATUS  = 12'h00C;
    localparam logic [11:0] OFS_FLAGS   = 12'h01C;
    localparam logic [11:0] OFS_CH_BASE = 12'h200;

    localparam int unsigned CH_STRIDE_SH = 5;
    localparam int unsigned MODE_POL_BIT = 9;

    typedef enum logic [2:0] {
        SEL_MODE,
        SEL_DUTY,
        SEL_DUTY_STG,
        SEL_PER,
        SEL_PER_STG,
        SEL_NONE
    } ch_sel_e;

    typedef struct packed {
        logic       pol;
        logic [3:0] pre;
    } ch_mode_t;

    function automatic ch_sel_e decode_slot(input logic [4:0] ofs);
        case (ofs)
            5'h00:   return SEL_MODE;
            5'h04:   return SEL_DUTY;
            5'h08:   return SEL_DUTY_STG;
            5'h0C:   return SEL_PER;
            5'h10:   return SEL_PER_STG;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic logic [3:0] clamp_pre(input logic [3:0] n);
        return (n > 4'(PWM_PRE_MAX)) ? 4'(PWM_PRE_MAX) : n;
    endfunction

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale
    import pwm_pkg::*;
#(
    parameter int unsigned DIV_W = PWM_PRE_MAX
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic [3:0] sel,
    output logic       tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;
    logic [3:0]       sel_eff;

    always_comb begin
        sel_eff = clamp_pre(sel);
        mask    = '0;
        for (int b = 0; b < DIV_W; b++) begin
            if (b < int'(sel_eff)) mask[b] = 1'b1;
        end
        tick = ((div_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) div_q <= '0;
        else                div_q <= div_q + 1'b1;
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int unsigned CNT_W = PWM_CNT_W,
    parameter int unsigned DIV_W = PWM_PRE_MAX
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  ch_sel_e          wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  ch_mode_t         wr_mode,
    input  logic             start,
    input  logic             stop,
    output logic             running,
    output logic             upd_done,
    output logic             wave,
    output ch_mode_t         rd_mode,
    output logic [CNT_W-1:0] rd_duty,
    output logic [CNT_W-1:0] rd_duty_stg,
    output logic [CNT_W-1:0] rd_per,
    output logic [CNT_W-1:0] rd_per_stg
);

    ch_mode_t         mode_q;
    logic [CNT_W-1:0] duty_q, per_q, duty_s, per_s, cnt_q;
    logic             duty_p, per_p, run_q, stop_q;
    logic             tick, last, pend_end;

    pwm_prescale #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .restart (start && !run_q),
        .sel     (mode_q.pre),
        .tick    (tick)
    );

    always_comb begin
        last     = ({1'b0, cnt_q} + 1'b1) >= {1'b0, per_q};
        pend_end = run_q && tick && last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            duty_q <= '0;
            per_q  <= '0;
            duty_s <= '0;
            per_s  <= '0;
            cnt_q  <= '0;
            duty_p <= 1'b0;
            per_p  <= 1'b0;
            run_q  <= 1'b0;
            stop_q <= 1'b0;
        end else begin
            if (pend_end) begin
                cnt_q <= '0;
                if (duty_p) duty_q <= duty_s;
                if (per_p)  per_q  <= per_s;
                duty_p <= 1'b0;
                per_p  <= 1'b0;
                if (stop_q) begin
                    run_q  <= 1'b0;
                    stop_q <= 1'b0;
                end
            end else if (run_q && tick) begin
                cnt_q <= cnt_q + 1'b1;
            end

            if (wr_en) begin
                case (wr_sel)
                    SEL_MODE: mode_q <= wr_mode;
                    SEL_DUTY, SEL_DUTY_STG: begin
                        duty_s <= wr_data;
                        if (run_q) duty_p <= 1'b1;
                        else       duty_q <= wr_data;
                    end
                    SEL_PER, SEL_PER_STG: begin
                        per_s <= wr_data;
                        if (run_q) per_p <= 1'b1;
                        else       per_q <= wr_data;
                    end
                    default: ;
                endcase
            end

            if (stop && run_q) stop_q <= 1'b1;

            if (start) begin
                stop_q <= 1'b0;
                if (!run_q) begin
                    run_q <= 1'b1;
                    cnt_q <= '0;
                end else if (pend_end) begin
                    run_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        running     = run_q;
        upd_done    = pend_end && (duty_p || per_p);
        wave        = (run_q && (cnt_q >= duty_q)) ? ~mode_q.pol : mode_q.pol;
        rd_mode     = mode_q;
        rd_duty     = duty_q;
        rd_duty_stg = duty_s;
        rd_per      = per_q;
        rd_per_stg  = per_s;
    end

    // R5
    stop_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(run_q) |-> ($past(stop_q) && $past(tick)));

    // R6
    hold_active_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q) && !$past(tick && last))
            |-> ($stable(duty_q) && $stable(per_q)));

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && per_q != '0) |-> (cnt_q < per_q));

    // R4
    start_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run_q) |-> (cnt_q == '0));

endmodule

// File: rtl/pwm_regif.sv
module pwm_regif
    import pwm_pkg::*;
#(
    parameter int unsigned NUM_CH = PWM_CH,
    parameter int unsigned CNT_W  = PWM_CNT_W,
    parameter int unsigned ADDR_W = PWM_ADDR_W,
    parameter int unsigned DATA_W = PWM_DATA_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    input  logic [NUM_CH-1:0]             running,
    input  logic [NUM_CH-1:0]             upd_done,
    input  ch_mode_t [NUM_CH-1:0]         rd_mode,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  rd_duty,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  rd_duty_stg,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  rd_per,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  rd_per_stg,
    output logic [NUM_CH-1:0]             ch_wr,
    output ch_sel_e                       ch_sel,
    output logic [CNT_W-1:0]              ch_wdata,
    output ch_mode_t                      ch_wmode,
    output logic [NUM_CH-1:0]             ch_start,
    output logic [NUM_CH-1:0]             ch_stop
);

    localparam int unsigned IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int unsigned CH_SPAN = NUM_CH << CH_STRIDE_SH;

    logic [ADDR_W-1:0] ofs;
    logic              in_ch;
    logic [IDX_W-1:0]  idx;
    ch_sel_e           slot;
    logic [NUM_CH-1:0] flags_q;
    logic              flag_rd;
    logic [DATA_W-1:0] rd_val;

    always_comb begin
        ofs      = bus_addr - ADDR_W'(OFS_CH_BASE);
        in_ch    = (bus_addr >= ADDR_W'(OFS_CH_BASE)) && (ofs < ADDR_W'(CH_SPAN));
        idx      = ofs[CH_STRIDE_SH +: IDX_W];
        slot     = in_ch ? decode_slot(ofs[4:0]) : SEL_NONE;
        flag_rd  = bus_rd && (bus_addr == ADDR_W'(OFS_FLAGS));
        ch_sel   = slot;
        ch_wdata = bus_wdata[CNT_W-1:0];
        ch_wmode = '{pol: bus_wdata[MODE_POL_BIT], pre: bus_wdata[3:0]};
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_strobe
        assign ch_wr[i]    = bus_wr && (slot != SEL_NONE) && (idx == IDX_W'(i));
        assign ch_start[i] = bus_wr && (bus_addr == ADDR_W'(OFS_START)) && bus_wdata[i];
        assign ch_stop[i]  = bus_wr && (bus_addr == ADDR_W'(OFS_STOP)) && bus_wdata[i];
    end

    always_comb begin
        rd_val = '0;
        if (bus_addr == ADDR_W'(OFS_STATUS)) begin
            rd_val[NUM_CH-1:0] = running;
        end else if (bus_addr == ADDR_W'(OFS_FLAGS)) begin
            rd_val[NUM_CH-1:0] = flags_q;
        end else begin
            case (slot)
                SEL_MODE: begin
                    rd_val[3:0]          = rd_mode[idx].pre;
                    rd_val[MODE_POL_BIT] = rd_mode[idx].pol;
                end
                SEL_DUTY:     rd_val[CNT_W-1:0] = rd_duty[idx];
                SEL_DUTY_STG: rd_val[CNT_W-1:0] = rd_duty_stg[idx];
                SEL_PER:      rd_val[CNT_W-1:0] = rd_per[idx];
                SEL_PER_STG:  rd_val[CNT_W-1:0] = rd_per_stg[idx];
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q   <= '0;
            bus_rdata <= '0;
        end else begin
            flags_q <= (flag_rd ? '0 : flags_q) | upd_done;
            if (bus_rd) bus_rdata <= rd_val;
        end
    end

    // R8
    isr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_rd && upd_done == '0) |=> (flags_q == '0));

    // R8
    isr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_rd |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
    import pwm_pkg::*;
#(
    parameter int unsigned NUM_CH = PWM_CH,
    parameter int unsigned CNT_W  = PWM_CNT_W,
    parameter int unsigned ADDR_W = PWM_ADDR_W,
    parameter int unsigned DATA_W = PWM_DATA_W,
    parameter int unsigned DIV_W  = PWM_PRE_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [NUM_CH-1:0]            running, upd_done, ch_wr, ch_start, ch_stop;
    ch_mode_t [NUM_CH-1:0]        rd_mode;
    logic [NUM_CH-1:0][CNT_W-1:0] rd_duty, rd_duty_stg, rd_per, rd_per_stg;
    ch_sel_e                      ch_sel;
    logic [CNT_W-1:0]             ch_wdata;
    ch_mode_t                     ch_wmode;

    pwm_regif #(
        .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regif (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .running     (running),
        .upd_done    (upd_done),
        .rd_mode     (rd_mode),
        .rd_duty     (rd_duty),
        .rd_duty_stg (rd_duty_stg),
        .rd_per      (rd_per),
        .rd_per_stg  (rd_per_stg),
        .ch_wr       (ch_wr),
        .ch_sel      (ch_sel),
        .ch_wdata    (ch_wdata),
        .ch_wmode    (ch_wmode),
        .ch_start    (ch_start),
        .ch_stop     (ch_stop)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwm_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ch (
            .clk         (clk),
            .rst         (rst),
            .wr_en       (ch_wr[i]),
            .wr_sel      (ch_sel),
            .wr_data     (ch_wdata),
            .wr_mode     (ch_wmode),
            .start       (ch_start[i]),
            .stop        (ch_stop[i]),
            .running     (running[i]),
            .upd_done    (upd_done[i]),
            .wave        (pwm_out[i]),
            .rd_mode     (rd_mode[i]),
            .rd_duty     (rd_duty[i]),
            .rd_duty_stg (rd_duty_stg[i]),
            .rd_per      (rd_per[i]),
            .rd_per_stg  (rd_per_stg[i])
        );
    end

endmodule

// File: tb/pwm_ctrl_tb.sv
module pwm_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int en_cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwm_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic logic [11:0] cha(input int ch, input int off);
        return 12'(32'h200 + ch * 32'h20 + off);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic expect_wave(input int k, input int neff, input int duty,
                                         input int per, input logic pol);
        int pos;
        pos = (k >> neff) % per;
        return (pos >= duty) ? ~pol : pol;
    endfunction

    task automatic wait_stop(input int ch);
        logic [31:0] v;
        v = 32'hFFFF_FFFF;
        for (int i = 0; i < 5000 && v[ch]; i++) rd(12'h00C, v);
        chk(v[ch] == 1'b0, "R5 channel stops", int'(v[ch]), 0);
    endtask

    task automatic run_wave(input int ch, input int nf, input int duty, input int per,
                            input logic pol, input int nper, input string req);
        int neff;
        int tot;
        neff = (nf > 10) ? 10 : nf;
        tot  = nper * per * (1 << neff);
        wr(cha(ch, 'h0), (32'(pol) << 9) | 32'(nf));
        wr(cha(ch, 'h4), 32'(duty));
        wr(cha(ch, 'hC), 32'(per));
        wr(12'h004, 32'(1) << ch);
        for (int k = 0; k < tot; k++) begin
            logic e;
            e = expect_wave(k, neff, duty, per, pol);
            chk(pwm_out[ch] == e, req, int'(pwm_out[ch]), int'(e));
            @(negedge clk);
        end
        wr(12'h008, 32'(1) << ch);
        wait_stop(ch);
        chk(pwm_out[ch] == pol, "R5 idle level", int'(pwm_out[ch]), int'(pol));
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        chk(pwm_out == 4'b0000, "R9 outputs", int'(pwm_out), 0);
        rd(12'h00C, v); chk(v == 0, "R9 status", int'(v), 0);
        rd(cha(0, 'h0), v); chk(v == 0, "R9 mode", int'(v), 0);
        rd(cha(3, 'hC), v); chk(v == 0, "R9 period", int'(v), 0);

        // R1 unused offsets
        rd(12'h010, v); chk(v == 0, "R1 unused global", int'(v), 0);
        rd(cha(1, 'h14), v); chk(v == 0, "R1 unused slot", int'(v), 0);
        rd(12'h280, v); chk(v == 0, "R1 past last channel", int'(v), 0);

        // R2 mode readback
        wr(cha(2, 'h0), 32'h0000_0207);
        rd(cha(2, 'h0), v); chk(v == 32'h207, "R2 mode readback", int'(v), 'h207);

        // R4 zero mask
        wr(12'h004, 32'h0);
        rd(12'h00C, v); chk(v == 0, "R4 zero mask", int'(v), 0);

        // R7 stopped channel loads live value
        wr(cha(1, 'h8), 32'd7);
        rd(cha(1, 'h4), v); chk(v == 7, "R7 direct load", int'(v), 7);

        // R3 and R2 waveform sweeps
        run_wave(0, 0, 2, 5, 1'b0, 2, "R3 basic");
        run_wave(1, 1, 0, 4, 1'b1, 2, "R3 duty zero");
        run_wave(2, 2, 4, 4, 1'b0, 2, "R3 duty equals period");
        run_wave(3, 3, 6, 4, 1'b1, 2, "R3 duty above period");
        run_wave(0, 0, 3, 7, 1'b1, 2, "R2 polarity low");
        run_wave(1, 15, 1, 2, 1'b0, 1, "R2 exponent clamp");
        rd(12'h01C, v); chk(v == 0, "R8 no flag without update", int'(v), 0);

        // R6 staging, R8 flag, R5 stop at boundary (ch2, N=4, P=8, D=2)
        wr(cha(2, 'h0), 32'd4);
        wr(cha(2, 'h4), 32'd2);
        wr(cha(2, 'hC), 32'd8);
        wr(12'h004, 32'h4); en_cyc = cyc;
        rd(12'h00C, v); chk(v[2] == 1'b1, "R4 status set", int'(v[2]), 1);
        wr(cha(2, 'h8), 32'd5);
        wr(cha(2, 'h10), 32'd6);
        rd(cha(2, 'h4), v);  chk(v == 2, "R6 live duty held", int'(v), 2);
        rd(cha(2, 'h8), v);  chk(v == 5, "R6 staged duty", int'(v), 5);
        rd(cha(2, 'hC), v);  chk(v == 8, "R6 live period held", int'(v), 8);
        rd(cha(2, 'h10), v); chk(v == 6, "R6 staged period", int'(v), 6);
        while (cyc - en_cyc < 400) begin
            int k;
            logic e;
            k = cyc - en_cyc;
            e = (k < 128) ? expect_wave(k, 4, 2, 8, 1'b0) : expect_wave(k - 128, 4, 5, 6, 1'b0);
            chk(pwm_out[2] == e, "R6 update at boundary", int'(pwm_out[2]), int'(e));
            @(negedge clk);
        end
        rd(12'h01C, v); chk(v == 32'h4, "R8 flag set", int'(v), 4);
        rd(12'h01C, v); chk(v == 0, "R8 read clears", int'(v), 0);
        rd(cha(2, 'h4), v); chk(v == 5, "R6 live duty applied", int'(v), 5);
        wr(12'h008, 32'h4);
        rd(12'h00C, v); chk(v[2] == 1'b1, "R5 status held", int'(v[2]), 1);
        while (cyc - en_cyc < 430) begin
            int k;
            logic e;
            k = cyc - en_cyc;
            e = (k < 416) ? expect_wave(k - 128, 4, 5, 6, 1'b0) : 1'b0;
            chk(pwm_out[2] == e, "R5 stop at boundary", int'(pwm_out[2]), int'(e));
            @(negedge clk);
        end
        rd(12'h00C, v); chk(v[2] == 1'b0, "R5 status cleared", int'(v[2]), 0);

        // R8 flag set in the same cycle as the clearing read (ch3, N=0, P=6, D=1)
        wr(cha(3, 'h0), 32'd0);
        wr(cha(3, 'h4), 32'd1);
        wr(cha(3, 'hC), 32'd6);
        wr(12'h004, 32'h8); en_cyc = cyc;
        wr(cha(3, 'h8), 32'd3);
        while (cyc - en_cyc != 5) @(negedge clk);
        rd(12'h01C, v); chk(v[3] == 1'b0, "R8 collision first read", int'(v[3]), 0);
        rd(12'h01C, v); chk(v[3] == 1'b1, "R8 collision flag kept", int'(v[3]), 1);
        wr(12'h008, 32'h8);
        wait_stop(3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule